// File: doc/BRIEF.md
# Five-bit PWM generator with shutdown

This block produces a pulse-width modulated output whose high time per period is set by a five-bit code. A prescaler divides the system clock into steps. Thirty-two steps make one output period. Settings arrive as single-cycle commands. One command selects a duty code. One selects a constant-high state for full 100% duty. Two more put the output into a floating sleep state and bring it back out again.

New duty and full-on settings are first held in a shadow register. They move into the active register only at the end of a period, so a period that has started is never cut short. In sleep the output-enable for the pad driver is dropped, and the period counter is held at its first step. On wake the block restarts from the beginning of a period. It uses the settings that were kept, or any written while it was asleep.

Top module: `pwm5_gen`

## Requirements
- R1: While reset is asserted, `pwm_out` and `pwm_oe` are low. After reset the block drives the output enabled at code 16 (50% duty) with full-on cleared.
- R2: One period is 32 steps of `TICK_DIV` clock cycles each. With full-on cleared, code n gives exactly n*`TICK_DIV` high cycles per period. Code 0 gives a constant low output.
- R3: Within a period the output is high during the first n steps (step index below the code) and low for the rest.
- R4: Command op 1 (full-on) makes the output high for whole periods. Command op 0 (set) loads `cmd_code` and clears full-on.
- R5: Set and full-on commands issued while running take effect only at the step-31-to-0 boundary. Each one shows on the output no later than two periods after the command.
- R6: Command op 2 (sleep) drops `pwm_oe` by the second clock edge after the command and holds `pwm_out` low while disabled.
- R7: Command op 3 (wake) re-enables the output. It keeps the earlier code and full-on state and restarts at step 0, so with code n the output is high for n*`TICK_DIV` cycles starting from the second edge after the command.
- R8: Set and full-on commands accepted while asleep take effect from the first period after wake.
- R9: While `cmd_valid` is low, `cmd_op` and `cmd_code` have no effect on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_op | input | 2 | 0 set code, 1 full-on, 2 sleep, 3 wake |
| cmd_code | input | DUTY_W | Duty code used by the set command |
| pwm_out | output | 1 | Modulated output level |
| pwm_oe | output | 1 | Output enable for the tri-state pad driver |

## Verification
The bench builds the block with `DUTY_W` = 5 and `TICK_DIV` = 3, which gives a 96-cycle period. With periods this short, every one of the 32 codes, the full-on state and several sleep and wake sequences fit in a run. Each of them is measured over whole periods. A divider of 3 also keeps the prescaler logic in use rather than its bypass variant. It makes the step boundary, the wrap-time load and the two-period update bound visible within a few hundred cycles.

// File: rtl/pwm5_pkg.sv
package pwm5_pkg;
  typedef enum logic [1:0] {
    OP_SET   = 2'd0,
    OP_FULL  = 2'd1,
    OP_SLEEP = 2'd2,
    OP_WAKE  = 2'd3
  } op_e;
endpackage

// File: rtl/pwm5_rst_sync.sv
module pwm5_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) pipe_q <= '0;
    else         pipe_q <= {pipe_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = pipe_q[STAGES-1];
endmodule

// File: rtl/pwm5_ticker.sv
module pwm5_ticker #(
  parameter int DIV    = 50,
  parameter int STEP_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold,
  output logic [STEP_W-1:0] step,
  output logic              wrap
);
  localparam logic [STEP_W-1:0] STEP_LAST = '1;

  logic              tick;
  logic [STEP_W-1:0] step_q, step_d;

  generate
    if (DIV == 1) begin : g_nodiv
      assign tick = !hold;
    end else begin : g_div
      localparam int PW = $clog2(DIV);
      localparam logic [PW-1:0] PRE_LAST = PW'(DIV - 1);
      logic [PW-1:0] pre_q, pre_d;

      always_comb begin
        pre_d = pre_q;
        if (hold)                  pre_d = '0;
        else if (pre_q == PRE_LAST) pre_d = '0;
        else                       pre_d = pre_q + 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
      end

      assign tick = !hold && (pre_q == PRE_LAST);
    end
  endgenerate

  always_comb begin
    step_d = step_q;
    if (hold)      step_d = '0;
    else if (tick) step_d = step_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) step_q <= '0;
    else        step_q <= step_d;
  end

  assign step = step_q;
  assign wrap = tick && (step_q == STEP_LAST);
endmodule

// File: rtl/pwm5_settings.sv
module pwm5_settings
  import pwm5_pkg::*;
#(
  parameter int DUTY_W = 5,
  parameter logic [DUTY_W-1:0] RESET_CODE = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [DUTY_W-1:0] cmd_code,
  input  logic              wrap,
  output logic [DUTY_W-1:0] act_code,
  output logic              act_full,
  output logic              sleep
);
  logic [DUTY_W-1:0] shd_code_q, shd_code_d, act_code_q, act_code_d;
  logic              shd_full_q, shd_full_d, act_full_q, act_full_d;
  logic              sleep_q, sleep_d;
  logic              act_load;

  always_comb begin
    shd_code_d = shd_code_q;
    shd_full_d = shd_full_q;
    sleep_d    = sleep_q;
    if (cmd_valid) begin
      unique case (op_e'(cmd_op))
        OP_SET:   begin shd_code_d = cmd_code; shd_full_d = 1'b0; end
        OP_FULL:  shd_full_d = 1'b1;
        OP_SLEEP: sleep_d = 1'b1;
        OP_WAKE:  sleep_d = 1'b0;
        default:  sleep_d = sleep_q;
      endcase
    end
  end

  assign act_load = wrap || sleep_q;

  always_comb begin
    act_code_d = act_code_q;
    act_full_d = act_full_q;
    if (act_load) begin
      act_code_d = shd_code_q;
      act_full_d = shd_full_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shd_code_q <= RESET_CODE;
      shd_full_q <= 1'b0;
      act_code_q <= RESET_CODE;
      act_full_q <= 1'b0;
      sleep_q    <= 1'b0;
    end else begin
      shd_code_q <= shd_code_d;
      shd_full_q <= shd_full_d;
      act_code_q <= act_code_d;
      act_full_q <= act_full_d;
      sleep_q    <= sleep_d;
    end
  end

  assign act_code = act_code_q;
  assign act_full = act_full_q;
  assign sleep    = sleep_q;
endmodule

// File: rtl/pwm5_drive.sv
module pwm5_drive #(
  parameter int DUTY_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DUTY_W-1:0] step,
  input  logic [DUTY_W-1:0] act_code,
  input  logic              act_full,
  input  logic              sleep,
  output logic              pwm_out,
  output logic              pwm_oe
);
  logic out_q, out_d, oe_q, oe_d;

  always_comb begin
    oe_d  = !sleep;
    out_d = !sleep && (act_full || (step < act_code));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      out_q <= out_d;
      oe_q  <= oe_d;
    end
  end

  assign pwm_out = out_q;
  assign pwm_oe  = oe_q;
endmodule

// File: rtl/pwm5_gen.sv
module pwm5_gen #(
  parameter int DUTY_W   = 5,
  parameter int TICK_DIV = 50
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [DUTY_W-1:0] cmd_code,
  output logic              pwm_out,
  output logic              pwm_oe
);
  localparam logic [DUTY_W-1:0] HALF_CODE = DUTY_W'(1 << (DUTY_W - 1));

  logic              srst_n;
  logic [DUTY_W-1:0] step;
  logic              wrap;
  logic [DUTY_W-1:0] act_code;
  logic              act_full;
  logic              sleep;

  pwm5_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .arst_n(rst_n), .srst_n(srst_n)
  );

  pwm5_ticker #(.DIV(TICK_DIV), .STEP_W(DUTY_W)) u_tick (
    .clk(clk), .rst_n(srst_n), .hold(sleep), .step(step), .wrap(wrap)
  );

  pwm5_settings #(.DUTY_W(DUTY_W), .RESET_CODE(HALF_CODE)) u_set (
    .clk(clk), .rst_n(srst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_code(cmd_code), .wrap(wrap), .act_code(act_code),
    .act_full(act_full), .sleep(sleep)
  );

  pwm5_drive #(.DUTY_W(DUTY_W)) u_drv (
    .clk(clk), .rst_n(srst_n), .step(step), .act_code(act_code),
    .act_full(act_full), .sleep(sleep), .pwm_out(pwm_out), .pwm_oe(pwm_oe)
  );
endmodule

// File: rtl/pwm5_gen_chk.sv
module pwm5_gen_chk #(
  parameter int DUTY_W = 5
) (
  input logic              clk,
  input logic              srst_n,
  input logic              cmd_valid,
  input logic [1:0]        cmd_op,
  input logic [DUTY_W-1:0] step,
  input logic              wrap,
  input logic [DUTY_W-1:0] act_code,
  input logic              act_full,
  input logic              sleep,
  input logic              pwm_out,
  input logic              pwm_oe
);
  // R6
  sleep_oe_low_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (cmd_valid && cmd_op == pwm5_pkg::OP_SLEEP) |=> ##1 !pwm_oe);

  // R6
  float_quiet_chk: assert property (@(posedge clk) disable iff (!srst_n)
    !pwm_oe |-> !pwm_out);

  // R4
  full_high_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (act_full && !sleep) |=> pwm_out);

  // R2
  zero_low_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (act_code == '0 && !act_full) |=> !pwm_out);

  // R5
  act_boundary_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (!$stable(act_code) || !$stable(act_full)) |-> $past(wrap || sleep));

  // R7
  wake_restart_chk: assert property (@(posedge clk) disable iff (!srst_n)
    $fell(sleep) |-> (step == '0));
endmodule

bind pwm5_gen pwm5_gen_chk #(.DUTY_W(DUTY_W)) u_chk (
  .clk(clk), .srst_n(srst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .step(step), .wrap(wrap), .act_code(act_code), .act_full(act_full),
  .sleep(sleep), .pwm_out(pwm_out), .pwm_oe(pwm_oe)
);

// File: tb/pwm5_gen_test.sv
module pwm5_gen_test;
  localparam int DW     = 5;
  localparam int DIV    = 3;
  localparam int STEPS  = 1 << DW;
  localparam int PERIOD = STEPS * DIV;

  logic          clk;
  logic          rst_n;
  logic          cmd_valid;
  logic [1:0]    cmd_op;
  logic [DW-1:0] cmd_code;
  logic          pwm_out;
  logic          pwm_oe;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  pwm5_gen #(.DUTY_W(DW), .TICK_DIV(DIV)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_code(cmd_code), .pwm_out(pwm_out), .pwm_oe(pwm_oe)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model, advanced on every rising edge
  int m_since, m_pre, m_step, m_scode, m_acode;
  bit m_sfull, m_afull, m_sleep, m_out, m_oe;

  task automatic model_reset();
    m_pre = 0; m_step = 0; m_scode = STEPS / 2; m_acode = STEPS / 2;
    m_sfull = 0; m_afull = 0; m_sleep = 0; m_out = 0; m_oe = 0;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_since = 0;
      model_reset();
    end else if (m_since < 2) begin
      m_since++;
      model_reset();
    end else begin
      bit n_out, n_oe, at_end;
      n_out  = !m_sleep && (m_afull || (m_step < m_acode));
      n_oe   = !m_sleep;
      at_end = !m_sleep && (m_pre == DIV - 1) && (m_step == STEPS - 1);
      if (m_sleep) begin
        m_acode = m_scode; m_afull = m_sfull; m_pre = 0; m_step = 0;
      end else begin
        if (at_end) begin m_acode = m_scode; m_afull = m_sfull; end
        if (m_pre == DIV - 1) begin
          m_pre = 0; m_step = (m_step + 1) % STEPS;
        end else m_pre++;
      end
      if (cmd_valid) begin
        case (cmd_op)
          2'd0: begin m_scode = int'(cmd_code); m_sfull = 0; end
          2'd1: m_sfull = 1;
          2'd2: m_sleep = 1;
          default: m_sleep = 0;
        endcase
      end
      m_out = n_out;
      m_oe  = n_oe;
    end
  end

  // Per-cycle comparison against the model (R3 shape, R5 update timing)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(pwm_out == m_out, "R3 R5 pwm_out vs model", int'(pwm_out), int'(m_out));
      check(pwm_oe == m_oe, "R6 pwm_oe vs model", int'(pwm_oe), int'(m_oe));
    end
  end

  task automatic send(input logic [1:0] op, input int code);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_op    = op;
    cmd_code  = DW'(code);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic window(output int hi, output int en);
    hi = 0; en = 0;
    for (int i = 0; i < PERIOD; i++) begin
      @(negedge clk);
      if (pwm_out) hi++;
      if (pwm_oe)  en++;
    end
  endtask

  task automatic settle();
    repeat (2 * PERIOD + 2) @(negedge clk);
  endtask

  task automatic high_run(output int run);
    run = 0;
    @(negedge clk);
    while (pwm_out && run <= PERIOD) begin
      run++;
      @(negedge clk);
    end
  endtask

  initial begin
    int hi, en, run;
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = 2'd0; cmd_code = '0;
    repeat (5) @(negedge clk);
    // R1: outputs low in reset
    check(pwm_out == 1'b0, "R1 out in reset", int'(pwm_out), 0);
    check(pwm_oe == 1'b0, "R1 oe in reset", int'(pwm_oe), 0);
    rst_n = 1'b1;
    settle();
    window(hi, en);
    check(hi == 16 * DIV, "R1 half duty after reset", hi, 16 * DIV);
    check(en == PERIOD, "R1 enabled after reset", en, PERIOD);

    // R2: every code over whole periods; R5: seen within two periods
    for (int c = 0; c < STEPS; c++) begin
      send(2'd0, c);
      repeat (2 * PERIOD - 2) @(negedge clk);
      window(hi, en);
      check(hi == c * DIV, "R2 R5 high count for code", hi, c * DIV);
    end

    // R4: full-on, then set clears it
    send(2'd1, 0);
    settle();
    window(hi, en);
    check(hi == PERIOD, "R4 full-on high count", hi, PERIOD);
    send(2'd0, 7);
    settle();
    window(hi, en);
    check(hi == 7 * DIV, "R4 set clears full-on", hi, 7 * DIV);

    // R6: sleep floats and quiets the output
    send(2'd2, 0);
    @(negedge clk);
    check(pwm_oe == 1'b0, "R6 oe low after sleep", int'(pwm_oe), 0);
    window(hi, en);
    check(hi == 0, "R6 no highs asleep", hi, 0);
    check(en == 0, "R6 disabled asleep", en, 0);

    // R7: wake restarts a period with preserved code
    send(2'd3, 0);
    high_run(run);
    check(run == 7 * DIV, "R7 first high run after wake", run, 7 * DIV);
    settle();
    window(hi, en);
    check(hi == 7 * DIV, "R7 preserved code after wake", hi, 7 * DIV);
    check(en == PERIOD, "R7 enabled after wake", en, PERIOD);

    // R8: setting written while asleep applies from the first period
    send(2'd2, 0);
    repeat (4) @(negedge clk);
    send(2'd0, 20);
    repeat (3) @(negedge clk);
    send(2'd3, 0);
    high_run(run);
    check(run == 20 * DIV, "R8 code written asleep", run, 20 * DIV);

    // R8: full-on written while asleep
    send(2'd2, 0);
    send(2'd1, 0);
    send(2'd3, 0);
    repeat (2) @(negedge clk);
    window(hi, en);
    check(hi == PERIOD, "R8 full-on written asleep", hi, PERIOD);
    send(2'd0, 20);
    settle();

    // R9: strobe low, op and code toggling, no effect
    @(negedge clk);
    cmd_op = 2'd2; cmd_code = 5'd3;
    window(hi, en);
    check(hi == 20 * DIV, "R9 ignored op sleep", hi, 20 * DIV);
    check(en == PERIOD, "R9 still enabled", en, PERIOD);
    cmd_op = 2'd1; cmd_code = 5'd0;
    window(hi, en);
    check(hi == 20 * DIV, "R9 ignored op full", hi, 20 * DIV);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule